// File: doc/BRIEF.md
# Multicycle Coprocessor Handshake Controller

This block is the custom-unit side of a tightly coupled coprocessor port on a pipelined processor core. Each cycle the core shows an instruction word, two 32-bit source operands, an active-low flag that says whether those operands are usable, a run-status flag that says the core is still stalled, and a kill flag. When the instruction carries the unit's own opcode, the unit claims it in that same cycle, so that the core does not treat it as reserved. The unit then stalls the core while a fixed-latency operation runs and hands the 32-bit result back on a result bus for writeback.

Operands may arrive late. Until the first cycle in which the operand flag is low, the unit keeps resampling and restarts its latency count. The stall output drops in the cycle the result first appears. If the core is still stalled for reasons of its own, the unit keeps the result on the bus until the core's run-status drops. A kill that arrives at any point from decode to the last driven cycle aborts the instruction with no result. The operation latency is a parameter with a default of 4. A build option can also keep the operand registers from loading until the operands are valid, which saves power.

Top module: `cxu_handshake`

## Requirements
- R1: An instruction is owned when insn_valid_i is high and insn_i[31:26] equals 6'h1C. In the decode cycle of an owned instruction, claim_o is high in that same cycle. It stays high in every later cycle until the last cycle in which the result is driven, or until the cycle of a kill. An instruction that is not owned never raises claim_o or stall_o.
- R2: The decode cycle raises stall_o when there is no kill. If opnd_vld_n_i is low in the decode cycle, the result first appears LATENCY-1 cycles after the decode cycle. stall_o is high in every cycle before that one.
- R3: While opnd_vld_n_i is high, the operands are treated as invalid and resampled. The latency count restarts from the first cycle in which opnd_vld_n_i is low. The result uses the operands presented in that cycle. After that cycle, opnd_vld_n_i has no effect.
- R4: stall_o falls in exactly the cycle in which result_vld_o first rises.
- R5: If core_stalled_i is high in a cycle where the result is driven, the same result stays on result_o with result_vld_o high in the next cycle. This continues through the first cycle in which core_stalled_i is low, and that cycle is the last one driven. stall_o stays low during this time.
- R6: kill_i high in any cycle from decode to the last driven cycle forces stall_o, result_vld_o and result_o to zero in that cycle. The unit then returns to idle, and the killed instruction produces no result in any later cycle.
- R7: result_o is zero in every cycle in which result_vld_o is low.
- R8: insn_i[1:0] selects the function. 0 gives the low 32 bits of a*b, 1 gives a+b, 2 gives a-b and 3 gives a XOR b, where a is src_a_i and b is src_b_i.
- R9: Reset is synchronous and active low. While rst_n is low, every output is zero. After reset the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid_i | input | 1 | Core presents an instruction in decode |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Second source operand |
| opnd_vld_n_i | input | 1 | Low when the operands are valid |
| core_stalled_i | input | 1 | High while the core is stalled |
| kill_i | input | 1 | Abort the instruction in flight |
| claim_o | output | 1 | Unit owns the current instruction |
| stall_o | output | 1 | Stall request to the core |
| result_o | output | 32 | Result bus, zero when not driven |
| result_vld_o | output | 1 | Result bus is driven |

## Verification
The two functions that can fall in the same cycle are completion, where the result first appears and the stall is released, and kill. The bench lines up a kill with exactly the completion cycle, and separately with a hold cycle, the decode cycle and a mid-operation cycle. In each case it judges the cycle at the ports: stall, result valid and the result bus must all read zero. No result may appear in the cycles that follow, even at the point where completion would have fallen. A second overlap is a late operand flag that arrives while the decode cycle is still claiming. This is judged by the result value and by the cycle in which the result appears.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_HOLD = 2'd2
    } cxu_state_e;

    typedef enum logic [1:0] {
        FN_MUL = 2'd0,
        FN_ADD = 2'd1,
        FN_SUB = 2'd2,
        FN_XOR = 2'd3
    } cxu_fn_e;

endpackage

// File: rtl/cxu_decode.sv
module cxu_decode #(
    parameter int              INSN_W = 32,
    parameter int              OPC_W  = 6,
    parameter logic [OPC_W-1:0] OPCODE = 6'h1C
) (
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic              owned_o,
    output cxu_pkg::cxu_fn_e  fn_o
);
    localparam int OPC_LSB = INSN_W - OPC_W;

    assign owned_o = insn_valid_i && (insn_i[INSN_W-1:OPC_LSB] == OPCODE);
    assign fn_o    = cxu_pkg::cxu_fn_e'(insn_i[1:0]);
endmodule

// File: rtl/cxu_datapath.sv
module cxu_datapath #(
    parameter int DATA_W     = 32,
    parameter bit WAIT_VALID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  cxu_pkg::cxu_fn_e  fn_i,
    input  logic              acq_i,
    input  logic              opnd_ok_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] res_o
);
    import cxu_pkg::*;

    typedef struct packed {
        cxu_fn_e           fn;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } dp_regs_t;

    localparam int PROD_W = 2 * DATA_W;

    dp_regs_t    dp_d, dp_q;
    logic        load;
    logic [PROD_W-1:0] prod;

    generate
        if (WAIT_VALID) begin : g_lowpower
            assign load = acq_i && opnd_ok_i;
        end else begin : g_eager
            assign load = acq_i;
        end
    endgenerate

    always_comb begin
        dp_d = dp_q;
        if (!rst_n) begin
            dp_d = '{fn: FN_MUL, a: '0, b: '0};
        end else begin
            if (accept_i) dp_d.fn = fn_i;
            if (load) begin
                dp_d.a = src_a_i;
                dp_d.b = src_b_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        dp_q <= dp_d;
    end

    assign prod = PROD_W'(dp_q.a) * PROD_W'(dp_q.b);

    always_comb begin
        unique case (dp_q.fn)
            FN_MUL:  res_o = prod[DATA_W-1:0];
            FN_ADD:  res_o = dp_q.a + dp_q.b;
            FN_SUB:  res_o = dp_q.a - dp_q.b;
            default: res_o = dp_q.a ^ dp_q.b;
        endcase
    end
endmodule

// File: rtl/cxu_ctrl.sv
module cxu_ctrl #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owned_i,
    input  logic opnd_vld_n_i,
    input  logic core_stalled_i,
    input  logic kill_i,
    output logic claim_o,
    output logic stall_o,
    output logic drive_o,
    output logic accept_o,
    output logic acq_o
);
    import cxu_pkg::*;

    localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY - 2);

    typedef struct packed {
        cxu_state_e       st;
        logic             opnd_ok;
        logic [CNT_W-1:0] cnt;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RST = '{st: ST_IDLE, opnd_ok: 1'b0, cnt: '0};

    ctrl_regs_t ctl_d, ctl_q;
    logic       opnd_vld;

    assign opnd_vld = !opnd_vld_n_i;

    always_comb begin
        ctl_d    = ctl_q;
        claim_o  = 1'b0;
        stall_o  = 1'b0;
        drive_o  = 1'b0;
        accept_o = 1'b0;
        acq_o    = 1'b0;
        if (!rst_n) begin
            ctl_d = CTRL_RST;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (owned_i) begin
                        claim_o = 1'b1;
                        if (!kill_i) begin
                            stall_o       = 1'b1;
                            accept_o      = 1'b1;
                            acq_o         = 1'b1;
                            ctl_d.st      = ST_EXEC;
                            ctl_d.opnd_ok = opnd_vld;
                            ctl_d.cnt     = CNT_INIT;
                        end
                    end
                end
                ST_EXEC: begin
                    claim_o = 1'b1;
                    if (kill_i) begin
                        ctl_d = CTRL_RST;
                    end else if (!ctl_q.opnd_ok) begin
                        stall_o = 1'b1;
                        acq_o   = 1'b1;
                        if (opnd_vld) begin
                            ctl_d.opnd_ok = 1'b1;
                            ctl_d.cnt     = CNT_INIT;
                        end
                    end else if (ctl_q.cnt == '0) begin
                        drive_o       = 1'b1;
                        ctl_d.opnd_ok = 1'b0;
                        ctl_d.st      = core_stalled_i ? ST_HOLD : ST_IDLE;
                    end else begin
                        stall_o   = 1'b1;
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    claim_o = 1'b1;
                    if (kill_i) begin
                        ctl_d = CTRL_RST;
                    end else begin
                        drive_o = 1'b1;
                        if (!core_stalled_i) ctl_d.st = ST_IDLE;
                    end
                end
                default: ctl_d = CTRL_RST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/cxu_handshake.sv
module cxu_handshake #(
    parameter int               DATA_W     = 32,
    parameter int               INSN_W     = 32,
    parameter int               OPC_W      = 6,
    parameter logic [OPC_W-1:0] OPCODE     = 6'h1C,
    parameter int               LATENCY    = 4,
    parameter bit               WAIT_VALID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic              opnd_vld_n_i,
    input  logic              core_stalled_i,
    input  logic              kill_i,
    output logic              claim_o,
    output logic              stall_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_vld_o
);
    logic             owned;
    cxu_pkg::cxu_fn_e fn;
    logic             drive;
    logic             accept;
    logic             acq;
    logic [DATA_W-1:0] res;

    cxu_decode #(
        .INSN_W (INSN_W),
        .OPC_W  (OPC_W),
        .OPCODE (OPCODE)
    ) u_decode (
        .insn_valid_i (insn_valid_i),
        .insn_i       (insn_i),
        .owned_o      (owned),
        .fn_o         (fn)
    );

    cxu_ctrl #(
        .LATENCY (LATENCY)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .owned_i        (owned),
        .opnd_vld_n_i   (opnd_vld_n_i),
        .core_stalled_i (core_stalled_i),
        .kill_i         (kill_i),
        .claim_o        (claim_o),
        .stall_o        (stall_o),
        .drive_o        (drive),
        .accept_o       (accept),
        .acq_o          (acq)
    );

    cxu_datapath #(
        .DATA_W     (DATA_W),
        .WAIT_VALID (WAIT_VALID)
    ) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .fn_i      (fn),
        .acq_i     (acq),
        .opnd_ok_i (!opnd_vld_n_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .res_o     (res)
    );

    assign result_vld_o = drive;
    assign result_o     = drive ? res : '0;
endmodule

// File: rtl/cxu_handshake_chk.sv
module cxu_handshake_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kill_i,
    input logic              claim_o,
    input logic              stall_o,
    input logic [DATA_W-1:0] result_o,
    input logic              result_vld_o
);
    AST_STALL_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> claim_o); // R1
    AST_DRIVE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld_o |-> claim_o); // R1
    AST_STALL_RELEASE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall_o) && !stall_o && !kill_i) |-> result_vld_o); // R4
    AST_NO_STALL_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld_o |-> !stall_o); // R4
    AST_HELD_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld_o && $past(result_vld_o) && $past(rst_n)) |-> $stable(result_o)); // R5
    AST_KILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |-> (!stall_o && !result_vld_o)); // R6
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld_o |-> (result_o == '0)); // R7
endmodule

bind cxu_handshake cxu_handshake_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kill_i       (kill_i),
    .claim_o      (claim_o),
    .stall_o      (stall_o),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
);

// File: tb/cxu_handshake_tb_top.sv
module cxu_handshake_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        opnd_vld_n_i = 1'b1;
    logic        core_stalled_i = 1'b0;
    logic        kill_i = 1'b0;
    logic        claim_o, stall_o, result_vld_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cxu_handshake #(.LATENCY(LAT)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .insn_valid_i   (insn_valid_i),
        .insn_i         (insn_i),
        .src_a_i        (src_a_i),
        .src_b_i        (src_b_i),
        .opnd_vld_n_i   (opnd_vld_n_i),
        .core_stalled_i (core_stalled_i),
        .kill_i         (kill_i),
        .claim_o        (claim_o),
        .stall_o        (stall_o),
        .result_o       (result_o),
        .result_vld_o   (result_vld_o)
    );

    typedef struct packed {
        logic [1:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  bad;
        logic [3:0]  hold;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h0000_0003, 32'h0000_0005, 4'd0, 4'd0, 32'h0000_000F},
        '{2'd1, 32'hFFFF_FFFF, 32'h0000_0002, 4'd1, 4'd0, 32'h0000_0001},
        '{2'd2, 32'h0000_0005, 32'h0000_0007, 4'd0, 4'd2, 32'hFFFF_FFFE},
        '{2'd3, 32'hA5A5_A5A5, 32'hFFFF_0000, 4'd2, 4'd1, 32'h5A5A_A5A5},
        '{2'd0, 32'h0001_0000, 32'h0001_0000, 4'd0, 4'd0, 32'h0000_0000},
        '{2'd0, 32'h0000_FFFF, 32'h0000_FFFF, 4'd1, 4'd3, 32'hFFFE_0001},
        '{2'd1, 32'h1234_5678, 32'h1111_1111, 4'd0, 4'd0, 32'h2345_6789},
        '{2'd2, 32'h0000_0000, 32'h0000_0001, 4'd3, 4'd0, 32'hFFFF_FFFF}
    };

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [1:0] fn);
        return {opc, 24'h0, fn};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // inputs applied at the falling edge, outputs sampled 2 ns later
    task automatic drive(input logic iv, input logic [31:0] insn, input logic [31:0] a,
                         input logic [31:0] b, input logic vn, input logic cs, input logic kl);
        @(negedge clk);
        insn_valid_i   = iv;
        insn_i         = insn;
        src_a_i        = a;
        src_b_i        = b;
        opnd_vld_n_i   = vn;
        core_stalled_i = cs;
        kill_i         = kl;
        #2;
    endtask

    task automatic idle_chk(input string tag);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
        chk({tag, " claim"}, 32'(claim_o), 32'd0);
        chk({tag, " stall"}, 32'(stall_o), 32'd0);
        chk({tag, " vld"}, 32'(result_vld_o), 32'd0);
        chk({tag, " bus"}, result_o, 32'd0);
    endtask

    task automatic run_op(input vec_t v);
        for (int k = 0; k <= int'(v.bad); k++) begin
            drive(k == 0, mk(6'h1C, v.fn), (k < int'(v.bad)) ? ~v.a : v.a,
                  (k < int'(v.bad)) ? (v.b ^ 32'h1357_9BDF) : v.b,
                  k < int'(v.bad), 1'b0, 1'b0);
            chk("R1 claim acq", 32'(claim_o), 32'd1);
            chk("R2 stall acq", 32'(stall_o), 32'd1);
            chk("R7 bus acq", result_o, 32'd0);
        end
        for (int k = 1; k < LAT - 1; k++) begin
            drive(1'b0, '0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b0);
            chk("R2 stall run", 32'(stall_o), 32'd1);
            chk("R3 no early result", 32'(result_vld_o), 32'd0);
        end
        drive(1'b0, '0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, v.hold != 0, 1'b0);
        chk("R4 stall at completion", 32'(stall_o), 32'd0);
        chk("R4 vld at completion", 32'(result_vld_o), 32'd1);
        chk("R8 R3 result", result_o, v.exp);
        for (int k = 1; k <= int'(v.hold); k++) begin
            drive(1'b0, '0, '0, '0, 1'b1, k < int'(v.hold), 1'b0);
            chk("R5 held vld", 32'(result_vld_o), 32'd1);
            chk("R5 held result", result_o, v.exp);
            chk("R5 stall low", 32'(stall_o), 32'd0);
            chk("R1 claim held", 32'(claim_o), 32'd1);
        end
        idle_chk("R5 after release");
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R9: reset state with an owned instruction presented
        drive(1'b1, mk(6'h1C, 2'd1), 32'd1, 32'd2, 1'b0, 1'b0, 1'b0);
        chk("R9 claim in reset", 32'(claim_o), 32'd0);
        chk("R9 stall in reset", 32'(stall_o), 32'd0);
        chk("R9 vld in reset", 32'(result_vld_o), 32'd0);
        chk("R9 bus in reset", result_o, 32'd0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle_chk("R9 after reset");

        // main table
        for (int i = 0; i < NVEC; i++) run_op(VECS[i]);

        // R1: not owned
        drive(1'b1, mk(6'h1D, 2'd1), 32'd1, 32'd2, 1'b0, 1'b0, 1'b0);
        chk("R1 foreign claim", 32'(claim_o), 32'd0);
        chk("R1 foreign stall", 32'(stall_o), 32'd0);
        idle_chk("R1 foreign next");
        drive(1'b1, mk(6'h1C, 2'd1), 32'd1, 32'd2, 1'b0, 1'b0, 1'b0);
        insn_valid_i = 1'b0;
        #1;
        chk("R1 valid low no claim", 32'(claim_o), 32'd0);
        idle_chk("R1 valid low next");

        // R6: kill in decode cycle
        drive(1'b1, mk(6'h1C, 2'd1), 32'd1, 32'd2, 1'b0, 1'b0, 1'b1);
        chk("R6 decode kill claim", 32'(claim_o), 32'd1);
        chk("R6 decode kill stall", 32'(stall_o), 32'd0);
        for (int k = 0; k < LAT + 1; k++) idle_chk("R6 after decode kill");

        // R6: kill mid operation
        drive(1'b1, mk(6'h1C, 2'd1), 32'd1, 32'd2, 1'b0, 1'b0, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b1);
        chk("R6 mid kill stall", 32'(stall_o), 32'd0);
        chk("R6 mid kill vld", 32'(result_vld_o), 32'd0);
        for (int k = 0; k < LAT + 1; k++) idle_chk("R6 after mid kill");

        // R6: kill in the completion cycle
        drive(1'b1, mk(6'h1C, 2'd3), 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k < LAT - 1; k++) drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b1, 1'b1);
        chk("R6 completion kill vld", 32'(result_vld_o), 32'd0);
        chk("R6 completion kill bus", result_o, 32'd0);
        chk("R6 completion kill stall", 32'(stall_o), 32'd0);
        for (int k = 0; k < 3; k++) idle_chk("R6 after completion kill");

        // R6: kill while holding
        drive(1'b1, mk(6'h1C, 2'd1), 32'd10, 32'd20, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k < LAT - 1; k++) drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b1, 1'b0);
        chk("R4 result before hold kill", result_o, 32'd30);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b1, 1'b1);
        chk("R6 hold kill vld", 32'(result_vld_o), 32'd0);
        chk("R6 hold kill bus", result_o, 32'd0);
        for (int k = 0; k < 3; k++) idle_chk("R6 after hold kill");

        // R9: reset in the middle of an operation
        drive(1'b1, mk(6'h1C, 2'd1), 32'd1, 32'd2, 1'b0, 1'b0, 1'b0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R9 mid reset stall", 32'(stall_o), 32'd0);
        chk("R9 mid reset claim", 32'(claim_o), 32'd0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < LAT; k++) idle_chk("R9 idle after mid reset");

        // unit still works afterwards
        run_op(VECS[2]);
        finish_run();
    end
endmodule